// File: doc/BRIEF.md
# Breakpoint Address Match Unit

This block watches the CPU bus of a small 8-bit core with 16-bit addresses and requests a break when the core touches a chosen address. Software programs the target address through two byte-wide registers. The upper register holds address bits 15..8 and the lower register holds bits 7..0. On every valid bus cycle, the block compares the bus address with the stored target. When breaking is enabled and the two are equal, it raises a one-clock break request toward the interrupt logic.

The core also reports whether it is in a stop or wait low-power state. When a break request arrives while that indication is high, the block sets a sticky status flag. A handler can read this flag to learn that the break ended a low-power state, and can then go back into that state. The flag is cleared by writing zero to its bit. Writing one to it does nothing.

Register reads are combinational on the bus address. Register writes take effect on the clock edge at which the write strobe is sampled.

Top module: `bkpt_unit`

## Requirements
- R1: After reset, the register at 0xFE0C (address bits 15..8) reads 0x00, the register at 0xFE0D (bits 7..0) reads 0x00, the status register at 0xFE00 reads 0x00, and `brk_req` is low.
- R2: A write strobe at 0xFE0C loads bits 15..8 of the target, and one at 0xFE0D loads bits 7..0. All 8 bits of each register are read back. The new value is visible only after the clock edge that samples the strobe.
- R3: `bus_rdata` follows `bus_addr` in the same cycle with no clock edge. Any address other than 0xFE0C, 0xFE0D or 0xFE00 reads 0x00.
- R4: `brk_req` is high in the cycle after a clock edge where `bus_valid` and `brk_en` are both high and `bus_addr` equals the 16-bit target. It lasts one cycle unless the matching cycle repeats.
- R5: `brk_req` stays low after any edge where `brk_en` is low, where `bus_valid` is low, or where `bus_addr` differs from the target in any bit.
- R6: The low-power break flag is bit 1 of the status register. It sets on an edge where a break request is raised while `core_lowpwr` is high.
- R7: A break request while `core_lowpwr` is low does not set the flag. Neither does `core_lowpwr` without a matching cycle. Once set, the flag holds until it is cleared.
- R8: Writing a byte with bit 1 = 0 to 0xFE00 clears the flag after that edge. Writing a byte with bit 1 = 1 leaves it unchanged.
- R9: Status bits 7..2 and bit 0 always read 0, whatever byte was written.
- R10: When the flag's set condition and a clearing write to 0xFE00 occur at the same edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 16 | CPU bus address |
| bus_valid | input | 1 | Bus cycle qualifier for the comparator |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on `bus_addr` |
| brk_en | input | 1 | Enables break requests |
| core_lowpwr | input | 1 | Core is in stop or wait state |
| brk_req | output | 1 | Break request, one cycle per matching bus cycle |

## Verification
The comparator is exercised with these patterns:
- an exact match with enable high;
- the same address with enable low;
- a match with the bus qualifier low;
- addresses that differ only in the lowest bit or only in the highest bit, which separates a full 16-bit compare from a partial one;
- a second target with alternating bit patterns, which catches swapped or stale byte lanes.

Flag behaviour is checked in three contexts:
- matches with and without the low-power indication;
- low power without a match;
- status writes with bit 1 set and with bit 1 clear.

The target is then placed on the status register's own address. This makes a clearing write and a low-power match fall on the same edge, which exposes the priority between set and clear.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    localparam int BK_ADDR_W = 16;
    localparam int BK_DATA_W = 8;

    typedef struct packed {
        logic flag;
    } stat_st_t;

    typedef struct packed {
        logic req;
    } match_st_t;

endpackage

// File: rtl/bkpt_regs.sv
module bkpt_regs #(
    parameter int ADDR_W = bkpt_pkg::BK_ADDR_W,
    parameter int DATA_W = bkpt_pkg::BK_DATA_W,
    parameter logic [ADDR_W-1:0] HI_ADDR = 16'hFE0C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int NLANE = ADDR_W / DATA_W;

    typedef struct packed {
        logic [ADDR_W-1:0] tgt;
    } regs_st_t;

    regs_st_t st_d, st_q;
    logic [NLANE-1:0]  lane_sel;
    logic [DATA_W-1:0] lane_rd [NLANE];

    // lane 0 is the least significant byte; the most significant byte sits at HI_ADDR
    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        localparam logic [ADDR_W-1:0] LANE_ADDR = ADDR_W'(HI_ADDR + (NLANE - 1 - i));
        assign lane_sel[i] = (bus_addr == LANE_ADDR);
        assign lane_rd[i]  = lane_sel[i] ? st_q.tgt[i*DATA_W +: DATA_W] : '0;
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NLANE; i++) begin
            if (bus_wr && lane_sel[i]) begin
                st_d.tgt[i*DATA_W +: DATA_W] = bus_wdata;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NLANE; i++) begin
            rd_data = rd_data | lane_rd[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tgt_addr = st_q.tgt;

endmodule

// File: rtl/bkpt_match.sv
module bkpt_match
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = bkpt_pkg::BK_ADDR_W,
    parameter int DATA_W = bkpt_pkg::BK_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_valid,
    input  logic              brk_en,
    input  logic [ADDR_W-1:0] tgt_addr,
    output logic              hit_now,
    output logic              brk_req
);

    localparam int NLANE = ADDR_W / DATA_W;

    match_st_t st_d, st_q;
    logic [NLANE-1:0] lane_eq;

    // byte-lane comparators, reduced below
    for (genvar i = 0; i < NLANE; i++) begin : g_cmp
        assign lane_eq[i] = (bus_addr[i*DATA_W +: DATA_W] == tgt_addr[i*DATA_W +: DATA_W]);
    end

    always_comb begin
        hit_now  = bus_valid && brk_en && (&lane_eq);
        st_d     = st_q;
        st_d.req = hit_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign brk_req = st_q.req;

endmodule

// File: rtl/bkpt_status.sv
module bkpt_status
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = bkpt_pkg::BK_ADDR_W,
    parameter int DATA_W = bkpt_pkg::BK_DATA_W,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFE00,
    parameter int FLAG_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              wr_flag_bit,
    input  logic              hit_now,
    input  logic              core_lowpwr,
    output logic              flag,
    output logic [DATA_W-1:0] rd_data
);

    stat_st_t st_d, st_q;
    logic sel, set_c, clr_c;

    always_comb begin
        sel   = (bus_addr == STAT_ADDR);
        set_c = hit_now && core_lowpwr;
        clr_c = bus_wr && sel && !wr_flag_bit;
        st_d  = st_q;
        // a set at the same edge overrides a clearing write
        if (set_c) begin
            st_d.flag = 1'b1;
        end else if (clr_c) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data           = '0;
        rd_data[FLAG_BIT] = sel && st_q.flag;
    end

    assign flag = st_q.flag;

endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit #(
    parameter int ADDR_W = bkpt_pkg::BK_ADDR_W,
    parameter int DATA_W = bkpt_pkg::BK_DATA_W,
    parameter logic [ADDR_W-1:0] HI_ADDR   = 16'hFE0C,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFE00,
    parameter int FLAG_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_valid,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              brk_en,
    input  logic              core_lowpwr,
    output logic              brk_req
);

    logic [ADDR_W-1:0] tgt_addr;
    logic [DATA_W-1:0] regs_rd, stat_rd;
    logic              hit_now;
    logic              flag;

    bkpt_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .HI_ADDR(HI_ADDR)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .tgt_addr (tgt_addr),
        .rd_data  (regs_rd)
    );

    bkpt_match #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_valid(bus_valid),
        .brk_en   (brk_en),
        .tgt_addr (tgt_addr),
        .hit_now  (hit_now),
        .brk_req  (brk_req)
    );

    bkpt_status #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .STAT_ADDR(STAT_ADDR),
        .FLAG_BIT (FLAG_BIT)
    ) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .wr_flag_bit(bus_wdata[FLAG_BIT]),
        .hit_now    (hit_now),
        .core_lowpwr(core_lowpwr),
        .flag       (flag),
        .rd_data    (stat_rd)
    );

    // address windows are disjoint, so an OR merges the read paths
    assign bus_rdata = regs_rd | stat_rd;

endmodule

// File: rtl/bkpt_unit_chk.sv
module bkpt_unit_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] HI_ADDR   = 16'hFE0C,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFE00,
    parameter int FLAG_BIT = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_valid,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              brk_en,
    input logic              core_lowpwr,
    input logic              brk_req,
    input logic [ADDR_W-1:0] tgt_addr,
    input logic              flag
);

    localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(HI_ADDR + (ADDR_W / DATA_W) - 1);
    localparam logic [DATA_W-1:0] FLAG_MASK = DATA_W'(1) << FLAG_BIT;

    logic match_c, set_c, clr_c;
    assign match_c = bus_valid && brk_en && (bus_addr == tgt_addr);
    assign set_c   = match_c && core_lowpwr;
    assign clr_c   = bus_wr && (bus_addr == STAT_ADDR) && !bus_wdata[FLAG_BIT];

    // R2
    hi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == HI_ADDR) |=> tgt_addr[ADDR_W-1 -: DATA_W] == $past(bus_wdata));

    // R2
    lo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == LO_ADDR) |=> tgt_addr[DATA_W-1:0] == $past(bus_wdata));

    // R4
    req_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_c |=> brk_req);

    // R5
    no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !match_c |=> !brk_req);

    // R6
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_c |=> flag);

    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_c && !clr_c) |=> $stable(flag));

    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_c && !set_c) |=> !flag);

    // R9
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == STAT_ADDR) |-> ((bus_rdata & ~FLAG_MASK) == '0));

endmodule

bind bkpt_unit bkpt_unit_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .HI_ADDR  (HI_ADDR),
    .STAT_ADDR(STAT_ADDR),
    .FLAG_BIT (FLAG_BIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_valid  (bus_valid),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .brk_en     (brk_en),
    .core_lowpwr(core_lowpwr),
    .brk_req    (brk_req),
    .tgt_addr   (tgt_addr),
    .flag       (flag)
);

// File: tb/tb_bkpt_unit.sv
module tb_bkpt_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_valid = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        brk_en = 1'b0;
    logic        core_lowpwr = 1'b0;
    logic        brk_req;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bkpt_unit dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_valid  (bus_valid),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .brk_en     (brk_en),
        .core_lowpwr(core_lowpwr),
        .brk_req    (brk_req)
    );

    localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_CMP = 2'd2;

    typedef struct packed {
        logic [1:0]  kind;
        logic [15:0] addr;
        logic [7:0]  data;
        logic        en;
        logic        lp;
        logic [7:0]  exp;
    } vec_t;

    localparam int NVEC = 22;
    localparam vec_t VECS [NVEC] = '{
        '{K_WR,  16'hFE0C, 8'h12, 1'b0, 1'b0, 8'h00},
        '{K_WR,  16'hFE0D, 8'h34, 1'b0, 1'b0, 8'h00},
        '{K_RD,  16'hFE0C, 8'h00, 1'b0, 1'b0, 8'h12}, // R2
        '{K_RD,  16'hFE0D, 8'h00, 1'b0, 1'b0, 8'h34}, // R2
        '{K_RD,  16'hFE01, 8'h00, 1'b0, 1'b0, 8'h00}, // R3 unmapped
        '{K_CMP, 16'h1234, 8'h00, 1'b1, 1'b0, 8'h01}, // R4
        '{K_RD,  16'hFE00, 8'h00, 1'b0, 1'b0, 8'h00}, // R7 no flag without low power
        '{K_CMP, 16'h1234, 8'h00, 1'b0, 1'b0, 8'h00}, // R5 disabled
        '{K_CMP, 16'h1235, 8'h00, 1'b1, 1'b0, 8'h00}, // R5 lsb differs
        '{K_CMP, 16'h9234, 8'h00, 1'b1, 1'b0, 8'h00}, // R5 msb differs
        '{K_CMP, 16'h1234, 8'h00, 1'b1, 1'b1, 8'h01}, // R4 match in low power
        '{K_RD,  16'hFE00, 8'h00, 1'b0, 1'b0, 8'h02}, // R6
        '{K_WR,  16'hFE00, 8'hFF, 1'b0, 1'b0, 8'h00},
        '{K_RD,  16'hFE00, 8'h00, 1'b0, 1'b0, 8'h02}, // R8 write one ignored, R9
        '{K_CMP, 16'h0000, 8'h00, 1'b1, 1'b1, 8'h00}, // R5 low power, no match
        '{K_RD,  16'hFE00, 8'h00, 1'b0, 1'b0, 8'h02}, // R7 flag sticky
        '{K_WR,  16'hFE00, 8'hFD, 1'b0, 1'b0, 8'h00},
        '{K_RD,  16'hFE00, 8'h00, 1'b0, 1'b0, 8'h00}, // R8 cleared, R9
        '{K_WR,  16'hFE0C, 8'hA5, 1'b0, 1'b0, 8'h00},
        '{K_WR,  16'hFE0D, 8'h5A, 1'b0, 1'b0, 8'h00},
        '{K_RD,  16'hFE0C, 8'h00, 1'b0, 1'b0, 8'hA5}, // R2
        '{K_CMP, 16'hA55A, 8'h00, 1'b1, 1'b0, 8'h01}  // R4 second target
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd_chk(input string tag, input logic [15:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_chk("R1 hi", 16'hFE0C, 8'h00);
        rd_chk("R1 lo", 16'hFE0D, 8'h00);
        rd_chk("R1 status", 16'hFE00, 8'h00);
        check("R1 req", {7'd0, brk_req}, 8'h00);
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            case (VECS[i].kind)
                K_WR: wr(VECS[i].addr, VECS[i].data);
                K_RD: begin
                    rd_chk($sformatf("vec%0d read", i), VECS[i].addr, VECS[i].exp);
                    @(negedge clk);
                end
                default: begin
                    bus_addr    = VECS[i].addr;
                    brk_en      = VECS[i].en;
                    core_lowpwr = VECS[i].lp;
                    bus_valid   = 1'b1;
                    @(posedge clk);
                    @(negedge clk);
                    check($sformatf("vec%0d req", i), {7'd0, brk_req}, VECS[i].exp);
                    bus_valid   = 1'b0;
                    brk_en      = 1'b0;
                    core_lowpwr = 1'b0;
                end
            endcase
        end

        // R4 pulse drops once the match goes away
        @(posedge clk);
        @(negedge clk);
        check("R4 one cycle", {7'd0, brk_req}, 8'h00);

        // R2 write not visible before the edge
        bus_addr  = 16'hFE0C;
        bus_wdata = 8'h77;
        bus_wr    = 1'b1;
        #1;
        check("R2 before edge", bus_rdata, 8'hA5);
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        rd_chk("R2 after edge", 16'hFE0C, 8'h77);

        // target on the status address
        wr(16'hFE0C, 8'hFE);
        wr(16'hFE0D, 8'h00);

        // R5 qualifier low
        bus_addr = 16'hFE00;
        brk_en   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R5 valid low", {7'd0, brk_req}, 8'h00);

        // R10 set and clear at the same edge
        bus_valid   = 1'b1;
        core_lowpwr = 1'b1;
        bus_wdata   = 8'h00;
        bus_wr      = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_valid = 1'b0; core_lowpwr = 1'b0;
        check("R4 match on status addr", {7'd0, brk_req}, 8'h01);
        rd_chk("R10 set wins", 16'hFE00, 8'h02);

        // R8 clear with a match but no low power
        bus_valid = 1'b1;
        bus_wr    = 1'b1;
        bus_wdata = 8'h00;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_valid = 1'b0; brk_en = 1'b0;
        rd_chk("R8 clear", 16'hFE00, 8'h00);

        // R1 reset mid-run
        wr(16'hFE0D, 8'h99);
        rst_n = 1'b0;
        #1;
        rst_n = 1'b1;
        rd_chk("R1 lo after reset", 16'hFE0D, 8'h00);
        rd_chk("R1 hi after reset", 16'hFE0C, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule